// File: doc/BRIEF.md
# Timestamp Event Capture Unit

A memory-mapped time-synchronization peripheral built around a free-running 32-bit timestamp counter that software can enable and preset. Whenever something of interest happens, the unit records the counter value together with a tag describing the cause into a 16-entry event queue. Software reads the oldest entry through two read-only words and then discards it with a pop write.

Nine sources can raise events. They are a software push, four hardware push pins, the counter wrapping and the counter crossing its half range, and Ethernet receive and transmit strobes. The two Ethernet strobes bring a PTP message type, a sequence number and a port number. Each source owns a one-deep holding slot, and a fixed-priority selector moves one slot per cycle into the queue. A level interrupt is raised while the queue holds anything. It is exposed through raw, enable and masked status words, and an interrupt test bit can force it.

Top module: `tsync_capture_unit`

## Requirements
- R1: The register bus uses a 4-bit word index with these decodes: 0 identification (reads parameter ID_VALUE), 1 control, 3 push, 4 load value, 5 load strobe, 8 raw status, 9 masked status, 10 interrupt enable, 12 pop, 13 event timestamp, 14 event tag. Writes take effect at the clock edge where reg_wen is high. reg_rdata returns the word selected by the reg_addr of the previous cycle. After reset, control, status and interrupt enable read 0 and irq is low.
- R2: While control bit 0 (unit enable) is set, the counter increments once per clock. While it is clear, the counter holds its value. Writing 1 to bit 0 at index 5 loads the counter with the load-value word on that edge.
- R3: Writing 1 to bit 0 of the push word records an event of kind 0 whose timestamp is the counter value just before that write edge.
- R4: When the counter steps from all ones to zero, a kind 1 event with timestamp 0 is recorded. When it steps from 0x7FFFFFFF to 0x80000000, a kind 2 event with timestamp 0x80000000 is recorded. A load never raises either event.
- R5: A rising edge on hw_pin[i] records a kind 3 event with port field i+1, but only if control bit 8+i is set. The edge is first passed through a two-stage synchronizer and an edge detector, so the timestamp is the counter value two cycles after the pin is sampled high. A pin whose enable bit is clear, and any falling edge, record nothing.
- R6: An rx_stb or tx_stb pulse records a kind 4 or kind 5 event that carries the strobe's message type, sequence number and port.
- R7: The tag word holds the port in bits 28:24, the kind in bits 23:20, the message type in bits 19:16 and the sequence number in bits 15:0, with bits 31:29 zero. Push, wrap and half events carry zero in their port, message and sequence fields.
- R8: The queue is first-in first-out with 16 entries. Writing 1 to bit 0 at index 12 removes the oldest entry. A pop of an empty queue does nothing. The event words read 0 while the queue is empty.
- R9: An event is dropped when the queue is full as it reaches the head of the selector, or when its source's slot still holds an earlier event. A drop sets the sticky overflow flag, raw status bit 1. Writing 1 to that bit clears it.
- R10: Raw status bit 0 is high while the queue is non-empty or while control bit 1 (interrupt test) is set. Masked status bit 0 is raw bit 0 AND interrupt-enable bit 0. irq follows masked status one cycle later.
- R11: While the unit enable is clear, the push write, the pins and the Ethernet strobes record nothing.
- R12: Events raised on the same edge enter the queue one per cycle in this order: software push, pins 1 to 4, wrap, half, receive, transmit. All of them keep the timestamp taken on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| hw_pin | input | N_PINS | Asynchronous hardware push pins |
| rx_stb | input | 1 | Ethernet receive timestamp strobe |
| rx_msg | input | 4 | Receive PTP message type |
| rx_seq | input | 16 | Receive sequence number |
| rx_port | input | 5 | Receive port number |
| tx_stb | input | 1 | Ethernet transmit timestamp strobe |
| tx_msg | input | 4 | Transmit PTP message type |
| tx_seq | input | 16 | Transmit sequence number |
| tx_port | input | 5 | Transmit port number |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the strobes and register writes are single-cycle pulses that are clean on the clock, and that the pins are quiet during reset. The bench drives every input on the falling edge and holds each pin level for many cycles, so the synchronizer always sees a settled level. Expected timestamps are derived from the edge times of the load and push writes. To keep that arithmetic exact, the stimulus reloads the counter after each enable change.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam logic [3:0] REG_ID    = 4'd0;
  localparam logic [3:0] REG_CTRL  = 4'd1;
  localparam logic [3:0] REG_PUSH  = 4'd3;
  localparam logic [3:0] REG_LOADV = 4'd4;
  localparam logic [3:0] REG_LOAD  = 4'd5;
  localparam logic [3:0] REG_RAW   = 4'd8;
  localparam logic [3:0] REG_MASK  = 4'd9;
  localparam logic [3:0] REG_INTEN = 4'd10;
  localparam logic [3:0] REG_POP   = 4'd12;
  localparam logic [3:0] REG_EVLO  = 4'd13;
  localparam logic [3:0] REG_EVHI  = 4'd14;

  typedef enum logic [3:0] {
    KIND_SWPUSH = 4'd0,
    KIND_WRAP   = 4'd1,
    KIND_HALF   = 4'd2,
    KIND_PIN    = 4'd3,
    KIND_RX     = 4'd4,
    KIND_TX     = 4'd5
  } ev_kind_e;

  typedef struct packed {
    logic [4:0]  port;
    logic [3:0]  kind;
    logic [3:0]  msg;
    logic [15:0] seq;
    logic [31:0] stamp;
  } tsu_entry_t;

  function automatic tsu_entry_t mk_entry(logic [4:0] port, ev_kind_e kind,
                                          logic [3:0] msg, logic [15:0] seq,
                                          logic [31:0] stamp);
    tsu_entry_t e;
    e.port  = port;
    e.kind  = kind;
    e.msg   = msg;
    e.seq   = seq;
    e.stamp = stamp;
    return e;
  endfunction
endpackage

// File: rtl/tsu_counter.sv
module tsu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap_ev,
  output logic         half_ev
);
  localparam logic [W-1:0] HALF_LAST = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] HALF_FIRST = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      wrap_ev <= 1'b0;
      half_ev <= 1'b0;
    end else begin
      wrap_ev <= 1'b0;
      half_ev <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (run) begin
        cnt     <= cnt + 1'b1;
        wrap_ev <= &cnt;
        half_ev <= (cnt == HALF_LAST);
      end
    end
  end

  // R4
  wrap_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_ev |-> cnt == '0);
  // R4
  half_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    half_ev |-> cnt == HALF_FIRST);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/tsu_arbiter.sv
module tsu_arbiter import tsu_pkg::*; #(
  parameter int N_SRC = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       fire,
  input  tsu_entry_t [N_SRC-1:0] ent_in,
  input  logic                   fifo_full,
  output logic                   wr_en,
  output tsu_entry_t             wr_data,
  output logic                   drop
);
  logic [N_SRC-1:0] held_q;
  tsu_entry_t [N_SRC-1:0] slot_q;
  logic [N_SRC-1:0] grant;
  logic collide;

  always_comb begin
    grant   = '0;
    wr_data = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (held_q[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        wr_data = slot_q[i];
      end
    end
  end

  assign collide = |(fire & held_q & ~grant);
  assign wr_en   = (|held_q) && !fifo_full;
  assign drop    = ((|held_q) && fifo_full) || collide;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (fire[i] && (!held_q[i] || grant[i])) held_q[i] <= 1'b1;
        else if (grant[i]) held_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SRC; i++) begin
      if (fire[i] && (!held_q[i] || grant[i])) slot_q[i] <= ent_in[i];
    end
  end

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R12
  grant_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|held_q && !fire[0]) |=> !(held_q[0] && $past(grant[0])));
endmodule

// File: rtl/tsu_fifo.sv
module tsu_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 61
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && full));
  // R8
  pop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty && !wr_en) |=> count == $past(count) - 1'b1);
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> empty);
endmodule

// File: rtl/tsync_capture_unit.sv
module tsync_capture_unit import tsu_pkg::*; #(
  parameter logic [31:0] ID_VALUE = 32'h5453_0101,
  parameter int FIFO_DEPTH = 16,
  parameter int N_PINS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_PINS-1:0] hw_pin,
  input  logic              rx_stb,
  input  logic [3:0]        rx_msg,
  input  logic [15:0]       rx_seq,
  input  logic [4:0]        rx_port,
  input  logic              tx_stb,
  input  logic [3:0]        tx_msg,
  input  logic [15:0]       tx_seq,
  input  logic [4:0]        tx_port,
  output logic              irq
);
  localparam int N_SRC = N_PINS + 5;
  localparam int S_SW = 0;
  localparam int S_WRAP = N_PINS + 1;
  localparam int S_HALF = N_PINS + 2;
  localparam int S_RX = N_PINS + 3;
  localparam int S_TX = N_PINS + 4;
  localparam int EW = $bits(tsu_entry_t);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [31:0] CTRL_MASK =
    32'h3 | ({{(32-N_PINS){1'b0}}, {N_PINS{1'b1}}} << 8);

  logic [31:0] ctrl_q, loadv_q, cnt;
  logic inten_q, ovf_q, unit_en, raw_pend;
  logic wrap_ev, half_ev, do_load, do_pop, drop, wr_en;
  logic [N_PINS-1:0] sync_q [SYNC_STAGES];
  logic [N_PINS-1:0] pin_prev, pin_rise;
  logic [N_SRC-1:0] fire;
  tsu_entry_t [N_SRC-1:0] ent;
  tsu_entry_t wr_data, head;
  logic [EW-1:0] head_raw;
  logic f_empty, f_full;
  logic [CW-1:0] f_count;

  function automatic logic hit(logic [3:0] idx);
    return reg_wen && (reg_addr == idx);
  endfunction

  assign unit_en  = ctrl_q[0];
  assign do_load  = hit(REG_LOAD) && reg_wdata[0];
  assign do_pop   = hit(REG_POP) && reg_wdata[0];
  assign raw_pend = !f_empty || ctrl_q[1];
  assign head     = tsu_entry_t'(head_raw);

  // Control, load value, interrupt enable, sticky overflow
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      loadv_q <= '0;
      inten_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (hit(REG_CTRL))  ctrl_q  <= reg_wdata & CTRL_MASK;
      if (hit(REG_LOADV)) loadv_q <= reg_wdata;
      if (hit(REG_INTEN)) inten_q <= reg_wdata[0];
      if (drop) ovf_q <= 1'b1;
      else if (hit(REG_RAW) && reg_wdata[1]) ovf_q <= 1'b0;
    end
  end

  // Pin synchronizer and edge detect
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      pin_prev <= '0;
    end else begin
      sync_q[0] <= hw_pin;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      pin_prev <= sync_q[SYNC_STAGES-1];
    end
  end
  assign pin_rise = sync_q[SYNC_STAGES-1] & ~pin_prev
                  & ctrl_q[8 +: N_PINS] & {N_PINS{unit_en}};

  // Event sources, index order sets queueing priority
  always_comb begin
    fire = '0;
    fire[S_SW]   = unit_en && hit(REG_PUSH) && reg_wdata[0];
    fire[S_WRAP] = wrap_ev;
    fire[S_HALF] = half_ev;
    fire[S_RX]   = unit_en && rx_stb;
    fire[S_TX]   = unit_en && tx_stb;
    ent[S_SW]   = mk_entry(5'd0, KIND_SWPUSH, 4'd0, 16'd0, cnt);
    ent[S_WRAP] = mk_entry(5'd0, KIND_WRAP, 4'd0, 16'd0, cnt);
    ent[S_HALF] = mk_entry(5'd0, KIND_HALF, 4'd0, 16'd0, cnt);
    ent[S_RX]   = mk_entry(rx_port, KIND_RX, rx_msg, rx_seq, cnt);
    ent[S_TX]   = mk_entry(tx_port, KIND_TX, tx_msg, tx_seq, cnt);
    for (int i = 0; i < N_PINS; i++) begin
      fire[1+i] = pin_rise[i];
      ent[1+i]  = mk_entry(5'(i + 1), KIND_PIN, 4'd0, 16'd0, cnt);
    end
  end

  tsu_counter #(.W(32)) u_counter (
    .clk(clk), .rst(rst), .run(unit_en), .load(do_load),
    .load_val(loadv_q), .cnt(cnt), .wrap_ev(wrap_ev), .half_ev(half_ev)
  );

  tsu_arbiter #(.N_SRC(N_SRC)) u_arbiter (
    .clk(clk), .rst(rst), .fire(fire), .ent_in(ent), .fifo_full(f_full),
    .wr_en(wr_en), .wr_data(wr_data), .drop(drop)
  );

  tsu_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(do_pop),
    .head(head_raw), .empty(f_empty), .full(f_full), .count(f_count)
  );

  // Registered read path and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= raw_pend && inten_q;
      case (reg_addr)
        REG_ID:    reg_rdata <= ID_VALUE;
        REG_CTRL:  reg_rdata <= ctrl_q;
        REG_LOADV: reg_rdata <= loadv_q;
        REG_RAW:   reg_rdata <= {30'd0, ovf_q, raw_pend};
        REG_MASK:  reg_rdata <= {31'd0, raw_pend && inten_q};
        REG_INTEN: reg_rdata <= {31'd0, inten_q};
        REG_EVLO:  reg_rdata <= f_empty ? 32'd0 : head.stamp;
        REG_EVHI:  reg_rdata <= f_empty ? 32'd0 :
                                {3'd0, head.port, head.kind, head.msg, head.seq};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!f_empty && inten_q) |=> irq);
  // R11
  off_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !unit_en |-> (fire & ~(N_SRC'(1) << S_WRAP) & ~(N_SRC'(1) << S_HALF)) == '0);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_q);
endmodule

// File: tb/test_tsync_capture_unit.sv
module test_tsync_capture_unit;
  import tsu_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_VAL = 32'h5453_0101;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wen = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] hw_pin = '0;
  logic rx_stb = 1'b0, tx_stb = 1'b0;
  logic [3:0] rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic [4:0] rx_port = '0, tx_port = '0;
  logic irq;

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  logic [31:0] ref_v;
  time ref_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsync_capture_unit #(.ID_VALUE(ID_VAL)) i_tsync_capture_unit (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
    .rx_stb(rx_stb), .rx_msg(rx_msg), .rx_seq(rx_seq), .rx_port(rx_port),
    .tx_stb(tx_stb), .tx_msg(tx_msg), .tx_seq(tx_seq), .tx_port(tx_port),
    .irq(irq)
  );

  function automatic logic [31:0] hi(logic [4:0] p, logic [3:0] k,
                                     logic [3:0] m, logic [15:0] s);
    return {3'd0, p, k, m, s};
  endfunction

  function automatic logic [31:0] stamp_at(time t);
    return ref_v + 32'((t - ref_t) / CLK_PERIOD) - 32'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, output time t);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    t = $time;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [31:0] v);
    time t;
    wr(REG_LOADV, v, t);
    wr(REG_LOAD, 32'd1, t);
    ref_v = v;
    ref_t = t;
  endtask

  // driver side of scoreboard
  task automatic expect_ev(logic [31:0] lo, logic [31:0] h);
    exp_q.push_back({h, lo});
  endtask

  // monitor side: read head, compare, pop
  task automatic drain(int n, string req);
    logic [31:0] lo, h;
    logic [63:0] e;
    time t;
    for (int i = 0; i < n; i++) begin
      rd(REG_EVLO, lo);
      rd(REG_EVHI, h);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s: actual=%h expected=empty scoreboard", req, h);
      end else begin
        e = exp_q.pop_front();
        chk({req, " stamp"}, lo, e[31:0]);
        chk({req, " tag R7"}, h, e[63:32]);
      end
      wr(REG_POP, 32'd1, t);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    time t, td, te, tp;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state and identification
    rd(REG_ID, d);    chk("R1 id", d, ID_VAL);
    rd(REG_CTRL, d);  chk("R1 ctrl", d, 32'd0);
    rd(REG_RAW, d);   chk("R1 raw", d, 32'd0);
    rd(REG_INTEN, d); chk("R1 inten", d, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R8 pop on empty queue ignored
    wr(REG_POP, 32'd1, t);
    rd(REG_EVLO, d); chk("R8 empty event word", d, 32'd0);

    // R3 software push
    wr(REG_CTRL, 32'd1, t);
    load(32'h0000_1000);
    idle(3);
    wr(REG_PUSH, 32'd1, t);
    expect_ev(stamp_at(t), hi(0, KIND_SWPUSH, 0, 0));
    idle(2);
    rd(REG_RAW, d); chk("R10 raw pending", d, 32'd1);
    drain(1, "R3");
    rd(REG_RAW, d); chk("R8 empty after pop", d, 32'd0);

    // R2 hold while disabled, R11 nothing captured while off
    load(32'h0002_0000);
    idle(4);
    wr(REG_CTRL, 32'd0, td);
    wr(REG_PUSH, 32'd1, t);
    @(negedge clk) rx_stb = 1'b1;
    @(negedge clk) rx_stb = 1'b0;
    idle(3);
    rd(REG_RAW, d); chk("R11 no capture when off", d, 32'd0);
    wr(REG_CTRL, 32'd1, te);
    idle(2);
    wr(REG_PUSH, 32'd1, tp);
    expect_ev(32'h0002_0000 + 32'((td - ref_t) / CLK_PERIOD)
              + 32'((tp - te) / CLK_PERIOD) - 32'd1, hi(0, KIND_SWPUSH, 0, 0));
    idle(2);
    drain(1, "R2");

    // R12 same-edge priority with R6 Ethernet strobes
    load(32'h0003_0000);
    idle(2);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = REG_PUSH; reg_wdata = 32'd1;
    rx_stb = 1'b1; rx_msg = 4'h3; rx_seq = 16'hBEEF; rx_port = 5'd17;
    tx_stb = 1'b1; tx_msg = 4'h9; tx_seq = 16'h0042; tx_port = 5'd2;
    @(posedge clk) t = $time;
    @(negedge clk);
    reg_wen = 1'b0; rx_stb = 1'b0; tx_stb = 1'b0;
    expect_ev(stamp_at(t), hi(0, KIND_SWPUSH, 0, 0));
    expect_ev(stamp_at(t), hi(5'd17, KIND_RX, 4'h3, 16'hBEEF));
    expect_ev(stamp_at(t), hi(5'd2, KIND_TX, 4'h9, 16'h0042));
    idle(4);
    drain(3, "R12 R6");

    // R4 wrap and half events
    load(32'hFFFF_FFFE);
    expect_ev(32'h0, hi(0, KIND_WRAP, 0, 0));
    idle(5);
    drain(1, "R4 wrap");
    load(32'h7FFF_FFFE);
    expect_ev(32'h8000_0000, hi(0, KIND_HALF, 0, 0));
    idle(5);
    drain(1, "R4 half");
    rd(REG_RAW, d); chk("R4 no extra event", d, 32'd0);

    // R5 pin 2 enabled, pin 1 disabled
    wr(REG_CTRL, 32'h0000_0201, t);
    load(32'h0005_0000);
    idle(2);
    @(negedge clk) hw_pin = 4'b0011;
    @(posedge clk) t = $time;
    expect_ev(ref_v + 32'((t - ref_t) / CLK_PERIOD) + 32'd1, hi(5'd2, KIND_PIN, 0, 0));
    idle(6);
    @(negedge clk) hw_pin = 4'b0000;
    idle(6);
    drain(1, "R5");
    rd(REG_RAW, d); chk("R5 disabled pin and fall ignored", d, 32'd0);

    // R9 overflow: 18 pushes, 16 kept
    wr(REG_CTRL, 32'd1, t);
    load(32'h0006_0000);
    for (int i = 0; i < 18; i++) begin
      wr(REG_PUSH, 32'd1, t);
      if (i < 16) expect_ev(stamp_at(t), hi(0, KIND_SWPUSH, 0, 0));
    end
    idle(2);
    rd(REG_RAW, d); chk("R9 overflow set", d, 32'd3);
    wr(REG_RAW, 32'd2, t);
    rd(REG_RAW, d); chk("R9 overflow cleared", d, 32'd1);
    drain(16, "R8 R9 order");
    rd(REG_RAW, d); chk("R8 drained", d, 32'd0);

    // R10 interrupt masking and test bit
    wr(REG_INTEN, 32'd1, t);
    idle(2);
    chk("R10 irq idle", {31'd0, irq}, 32'd0);
    wr(REG_PUSH, 32'd1, t);
    expect_ev(stamp_at(t), hi(0, KIND_SWPUSH, 0, 0));
    idle(3);
    chk("R10 irq on event", {31'd0, irq}, 32'd1);
    drain(1, "R10");
    idle(2);
    chk("R10 irq after drain", {31'd0, irq}, 32'd0);
    wr(REG_CTRL, 32'd3, t);
    idle(2);
    chk("R10 irq test bit", {31'd0, irq}, 32'd1);
    rd(REG_MASK, d); chk("R10 masked", d, 32'd1);
    wr(REG_INTEN, 32'd0, t);
    idle(2);
    chk("R10 irq masked off", {31'd0, irq}, 32'd0);
    rd(REG_MASK, d); chk("R10 masked off", d, 32'd0);
    rd(REG_RAW, d);  chk("R10 raw test", d, 32'd1);
    wr(REG_CTRL, 32'd1, t);
    rd(REG_RAW, d);  chk("R10 raw test clear", d, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule